// File: doc/BRIEF.md
# Ethernet PHY Management Frame Master

This block runs the serial management bus of an Ethernet PHY. It reads or writes one 16-bit PHY register for each start strobe. The host side supplies a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 data bits. The block then produces the management clock and drives the data pin. For reads it releases the pin at the right point and samples the PHY's reply. When the frame ends it returns the read word, an error flag and a one-cycle done pulse.

The management clock comes from the system clock. Each clock level is a whole number of system cycles, set by the parameter `HALF_CYC`. Its default of 20 gives 2.5 MHz from a 100 MHz system clock. A frame opens with a run of ones that lets the PHY synchronise. Next come the start code, the opcode and the two addresses. The frame then ends in one of two ways:

- **Write:** a master-driven turnaround and the data word.
- **Read:** the bus is handed over to the PHY. The master checks that the PHY acknowledged the turnaround, then shifts in 16 bits.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever `busy` is low, `mdc` is low, `mdio_oe` is 1, `mdio_o` is 1 and `done` is low.
- R2: Every frame begins with 32 rising edges of `mdc` during which the driven line is 1.
- R3: The next 14 rising edges carry, MSB first: the start code 01, the opcode (10 for read, 01 for write), the 5-bit PHY address and the 5-bit register address. The PHY samples each bit on the rising edge of `mdc`.
- R4: Each output bit is changed only while `mdc` is low and has been low for a full half-period. It stays unchanged through the following high pulse and the low phase after it, so each bit takes a low-high-low sequence.
- R5: A write continues with the turnaround pattern 10 and then the 16 data bits, MSB first, for 64 rising edges in all. The master still drives the line after the last bit.
- R6: On a read, `mdio_oe` falls after the register address and rises again after the last data bit. Each of these changes happens only when `mdc` is low in that cycle and in the cycle before.
- R7: On a read there is one turnaround pulse and then one idle pulse. Each of the 16 data bits is sampled in the system cycle just before a rising edge of `mdc` (rising edges 49 to 64), MSB first. When the PHY acknowledged, `rd_data` carries the word and `err` is 0 at `done`.
- R8: If the line is high when sampled in the low phase after the turnaround pulse, the read ends with `err` = 1 and `rd_data` = 0. All 64 rising edges are still issued.
- R9: `busy` is high from the cycle after an accepted `start` until the cycle `done` is high. A `start` seen while `busy` is high is ignored and produces no second frame.
- R10: `done` is a one-cycle pulse. It is high in the cycle after the (P·`HALF_CYC`)-th clock edge that follows the edge accepting `start`, where P = 192 for a write and P = 176 for a read.
- R11: Every high pulse of `mdc` lasts exactly `HALF_CYC` system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one frame; accepted only while idle |
| rd_nwr | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address within the PHY |
| wr_data | input | 16 | Word to write |
| rd_data | output | 16 | Word read back; zero after a failed read |
| done | output | 1 | One-cycle pulse at the end of a frame |
| err | output | 1 | Read got no acknowledge; valid with `done` |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value driven onto the pin |
| mdio_oe | output | 1 | Output enable of the data pin |
| mdio_i | input | 1 | Level seen on the data pin |

## Verification
The `done` pulse is due exactly P·`HALF_CYC`+1 negative clock edges after `start` is raised. The bench counts those edges and checks `done`, `rd_data` and `err` at that sample and no sooner.

Bus content is checked on rising edges of `mdc`, the same instant the PHY would sample it. A PHY model counts rising edges and changes its reply on the falling edge after the turnaround and on the rising edges that follow. Its reply is therefore settled a full half-period before the master samples it.

A monitor on every negative clock edge checks:
- data stability around the clock (R4);
- direction changes against the clock level (R6);
- the length of each high pulse (R11);
- bus contention.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 32;   // header + turnaround + data word
    localparam int PRE_LEN    = 32;   // preamble pulses
    localparam int HDR_LEN    = 14;   // start + opcode + two addresses
    localparam int WTAIL_LEN  = 18;   // turnaround + data word
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 5;

    localparam logic [1:0] SOF_CODE = 2'b01;
    localparam logic [1:0] OPC_RD   = 2'b10;
    localparam logic [1:0] OPC_WR   = 2'b01;
    localparam logic [1:0] TURN_WR  = 2'b10;

    typedef enum logic [3:0] {
        S_IDLE,   // bus parked
        S_PRE,    // preamble ones
        S_HDR,    // start, opcode, addresses
        S_WOUT,   // write turnaround and data
        S_REL,    // release pin, clock held low
        S_TA,     // turnaround pulse, check acknowledge
        S_GAP,    // idle pulse before data
        S_RIN,    // shift in read data
        S_RET     // take pin back, clock held low
    } seq_state_t;

    typedef struct packed {
        logic       mdc;
        logic       dout;
        logic       oe;
    } pin_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic              rd,
        input logic [ADDR_W-1:0] phy,
        input logic [ADDR_W-1:0] regn,
        input logic [DATA_W-1:0] wdat
    );
        return {SOF_CODE, (rd ? OPC_RD : OPC_WR), phy, regn, TURN_WR, wdat};
    endfunction

endpackage

// File: rtl/mdio_tick.sv
module mdio_tick #(
    parameter int HALF_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart)   cnt <= RELOAD;
        else if (cnt == '0)   cnt <= RELOAD;
        else                  cnt <= cnt - 1'b1;
    end

    assign tick = (cnt == '0);
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mdio_i,
    input  logic              tick,
    output logic              restart,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_data,
    output pin_t              pins
);
    seq_state_t            st;
    logic [1:0]            ph;
    logic [4:0]            bitn;
    logic [FRAME_BITS-1:0] sh;
    logic [DATA_W-1:0]     rsh;
    logic                  is_rd;
    logic                  nack;

    assign restart = (st == S_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            ph      <= '0;
            bitn    <= '0;
            sh      <= '0;
            rsh     <= '0;
            is_rd   <= 1'b0;
            nack    <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
            rd_data <= '0;
            pins    <= '{mdc: 1'b0, dout: 1'b1, oe: 1'b1};
        end else begin
            done <= 1'b0;
            if (st == S_IDLE) begin
                if (start) begin
                    st    <= S_PRE;
                    ph    <= '0;
                    bitn  <= '0;
                    sh    <= build_frame(rd_nwr, phy_addr, reg_addr, wr_data);
                    is_rd <= rd_nwr;
                    busy  <= 1'b1;
                    pins  <= '{mdc: 1'b0, dout: 1'b1, oe: 1'b1};
                end
            end else if (tick) begin
                unique case (st)
                    S_PRE, S_HDR, S_WOUT: begin
                        if (ph == 2'd0) begin
                            pins.mdc <= 1'b1;
                            ph       <= 2'd1;
                        end else if (ph == 2'd1) begin
                            pins.mdc <= 1'b0;
                            ph       <= 2'd2;
                        end else begin
                            ph <= 2'd0;
                            if (st == S_PRE && bitn != 5'(PRE_LEN - 1)) begin
                                bitn <= bitn + 1'b1;
                            end else if (st == S_HDR && bitn == 5'(HDR_LEN - 1) && is_rd) begin
                                st        <= S_REL;
                                pins.oe   <= 1'b0;
                                pins.dout <= 1'b1;
                            end else if (st == S_WOUT && bitn == 5'(WTAIL_LEN - 1)) begin
                                st        <= S_IDLE;
                                busy      <= 1'b0;
                                done      <= 1'b1;
                                err       <= 1'b0;
                                pins.dout <= 1'b1;
                            end else begin
                                if (st == S_PRE || (st == S_HDR && bitn == 5'(HDR_LEN - 1))) begin
                                    st   <= (st == S_PRE) ? S_HDR : S_WOUT;
                                    bitn <= '0;
                                end else begin
                                    bitn <= bitn + 1'b1;
                                end
                                pins.dout <= sh[FRAME_BITS-1];
                                sh        <= {sh[FRAME_BITS-2:0], 1'b0};
                            end
                        end
                    end
                    S_REL: begin
                        st       <= S_TA;
                        ph       <= 2'd0;
                        pins.mdc <= 1'b1;
                    end
                    S_TA, S_GAP, S_RIN: begin
                        if (ph == 2'd0) begin
                            pins.mdc <= 1'b0;
                            ph       <= 2'd1;
                        end else if (st == S_RIN && bitn == 5'(DATA_W - 1)) begin
                            st      <= S_RET;
                            pins.oe <= 1'b1;
                        end else begin
                            ph       <= 2'd0;
                            pins.mdc <= 1'b1;
                            if (st == S_TA) begin
                                nack <= mdio_i;
                                st   <= S_GAP;
                            end else begin
                                rsh <= {rsh[DATA_W-2:0], mdio_i};
                                if (st == S_GAP) begin
                                    st   <= S_RIN;
                                    bitn <= '0;
                                end else begin
                                    bitn <= bitn + 1'b1;
                                end
                            end
                        end
                    end
                    S_RET: begin
                        st      <= S_IDLE;
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        err     <= nack;
                        rd_data <= nack ? '0 : rsh;
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_CYC = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        rd_nwr,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        done,
    output logic        err,
    output logic        busy,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic tick;
    logic restart;
    pin_t pins;

    mdio_tick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (tick)
    );

    mdio_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .rd_nwr   (rd_nwr),
        .phy_addr (phy_addr),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .mdio_i   (mdio_i),
        .tick     (tick),
        .restart  (restart),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .rd_data  (rd_data),
        .pins     (pins)
    );

    assign mdc     = pins.mdc;
    assign mdio_o  = pins.dout;
    assign mdio_oe = pins.oe;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic [15:0] rd_data,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    a_r1_idle_levels: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && mdio_oe && mdio_o));

    a_r4_hold_high: assert property (@(posedge clk) disable iff (rst)
        mdc |-> $stable(mdio_o));

    a_r4_hold_after_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(mdc) |-> $stable(mdio_o));

    a_r6_dir_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_oe) |-> (!mdc && !$past(mdc)));

    a_r8_err_zero: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (rd_data == 16'h0000));

    a_r9_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .rd_data (rd_data),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        rd_nwr = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        done, err, busy, mdc, mdio_o, mdio_oe;
    logic        line;

    logic        phy_en = 1'b0;
    logic        phy_val = 1'b1;
    logic        cur_rd = 1'b0;
    logic        cur_bad = 1'b0;
    logic [15:0] cur_rdat = '0;
    int          base = 0;
    int          nrise = 0;
    logic [63:0] cap = '0;

    int checks = 0;
    int fails = 0;
    int v_hold = 0, v_dir = 0, v_hi = 0, v_cont = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    assign line = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

    mdio_master #(.HALF_CYC(HALF)) u0 (
        .clk(clk), .rst(rst), .start(start), .rd_nwr(rd_nwr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .rd_data(rd_data), .done(done), .err(err), .busy(busy),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(line)
    );

    // PHY model: captures on rising edges, replies on read frames
    always @(posedge mdc) begin
        int rel;
        rel = nrise - base;
        nrise <= nrise + 1;
        cap   <= {cap[62:0], line};
        if (cur_rd) begin
            if (rel >= 47 && rel <= 62) phy_val <= cur_rdat[62 - rel];
            if (rel == 63) phy_en <= 1'b0;
        end
    end

    always @(negedge mdc) begin
        if (cur_rd && (nrise - base) == 47) begin
            phy_en  <= 1'b1;
            phy_val <= cur_bad;
        end
    end

    // Pin monitor
    logic prev_mdc = 1'b0, prev_o = 1'b1, prev_oe = 1'b1;
    int   hi_len = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (mdc && mdio_oe && (mdio_o !== prev_o)) v_hold++;
            if ((mdio_oe !== prev_oe) && (mdc || prev_mdc)) v_dir++;
            if (mdc) hi_len++;
            else if (prev_mdc) begin
                if (hi_len != HALF) v_hi++;
                hi_len = 0;
            end
            if (phy_en && mdio_oe) v_cont++;
        end
        prev_mdc = mdc;
        prev_o   = mdio_o;
        prev_oe  = mdio_oe;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, input logic [15:0] rdat, input bit bad,
                       input bit poke);
        int n;
        int exp_lat;
        logic [13:0] hdr;
        @(negedge clk);
        rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
        cur_rd = rd; cur_rdat = rdat; cur_bad = bad;
        base = nrise;
        start = 1'b1;
        n = 0;
        forever begin
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            n++;
            if (poke && n == 50) begin
                check(busy == 1'b1, "R9 busy mid-frame", 64'(busy), 64'd1);
                start = 1'b1; rd_nwr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd;
            end
            if (done || n > 5000) break;
        end
        exp_lat = (rd ? 176 : 192) * HALF + 1;
        check(n == exp_lat, "R10 done latency", 64'(n), 64'(exp_lat));
        check(busy == 1'b0, "R9 busy low at done", 64'(busy), 64'd0);
        check(nrise - base == 64, rd ? "R7 rising edge count" : "R5 rising edge count",
              64'(nrise - base), 64'd64);
        check(cap[63:32] == 32'hFFFF_FFFF, "R2 preamble", cap[63:32], 64'hFFFF_FFFF);
        hdr = {2'b01, (rd ? 2'b10 : 2'b01), pa, ra};
        check(cap[31:18] == hdr, "R3 header", 64'(cap[31:18]), 64'(hdr));
        if (!rd) begin
            check(cap[17:0] == {2'b10, wd}, "R5 turnaround and data", 64'(cap[17:0]), 64'({2'b10, wd}));
            check(err == 1'b0, "R5 no error on write", 64'(err), 64'd0);
        end else if (bad) begin
            check(err == 1'b1, "R8 error flag", 64'(err), 64'd1);
            check(rd_data == 16'h0, "R8 zero data", 64'(rd_data), 64'd0);
        end else begin
            check(err == 1'b0, "R7 error flag", 64'(err), 64'd0);
            check(rd_data == rdat, "R7 read data", 64'(rd_data), 64'(rdat));
        end
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", 64'(done), 64'd0);
        check(!mdc && mdio_oe && mdio_o, "R1 idle after frame",
              64'({mdc, mdio_oe, mdio_o}), 64'b011);
        if (poke) begin
            repeat (200 * HALF) @(negedge clk);
            check(nrise - base == 64 && !busy, "R9 start while busy ignored",
                  64'(nrise - base), 64'd64);
        end
        cur_rd = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!mdc && mdio_oe && mdio_o && !busy && !done, "R1 reset state",
              64'({mdc, mdio_oe, mdio_o, busy, done}), 64'b01100);

        for (int p = 0; p < 32; p++) begin
            txn(p[0], 5'(p), 5'(31 - p), 16'(p * 1031) ^ 16'hA5C3, 16'(p * 4099) ^ 16'h3C5A, 1'b0, 1'b0);
        end
        txn(1'b0, 5'h1F, 5'h00, 16'h0000, 16'h0, 1'b0, 1'b0);
        txn(1'b0, 5'h00, 5'h1F, 16'hFFFF, 16'h0, 1'b0, 1'b0);
        txn(1'b1, 5'h15, 5'h0A, 16'h0, 16'hFFFF, 1'b0, 1'b0);
        txn(1'b1, 5'h0A, 5'h15, 16'h0, 16'h0000, 1'b0, 1'b0);
        txn(1'b1, 5'h03, 5'h04, 16'h0, 16'hBEEF, 1'b1, 1'b0);
        txn(1'b1, 5'h1C, 5'h11, 16'h0, 16'hFFFF, 1'b1, 1'b0);
        txn(1'b1, 5'h07, 5'h09, 16'h0, 16'h8001, 1'b0, 1'b1);
        txn(1'b0, 5'h12, 5'h0D, 16'h7E81, 16'h0, 1'b0, 1'b1);
        txn(1'b1, 5'h01, 5'h02, 16'h0, 16'h1234, 1'b0, 1'b0);

        check(v_hold == 0, "R4 data stable around clock high", 64'(v_hold), 64'd0);
        check(v_dir == 0, "R6 direction change with clock low", 64'(v_dir), 64'd0);
        check(v_hi == 0, "R11 high pulse length", 64'(v_hi), 64'd0);
        check(v_cont == 0, "R6 no bus contention", 64'(v_cont), 64'd0);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule